// File: doc/BRIEF.md
# Interrupt Status and Mask Expander

This block gathers up to 23 single-cycle event pulses from neighbouring functions into a sticky pending register. It pairs that register with a mask register and drives a single interrupt request towards the host processor. The host reaches both registers through a simple register port: a write strobe, an address, a 25-bit write word, and a combinational read word.

The host handles the interrupt line on its rising edge. When the host clears one pending event and others remain unmasked, the block holds the line low for one cycle and then raises it again. This gives the host a fresh edge for the remaining work. Pending bits are recorded whether or not they are masked, so unmasking a bit that is already pending raises the line at once.

Top module: `irq_status_mask`

## Requirements
- R1: After reset the pending register reads 0, the mask register reads 0x077FFFF (all implemented bits set), and irq_o is low.
- R2: The pending register is at address 0 and the mask register at address 1. Any other address reads 0, and a write to any other address changes neither register.
- R3: An event pulse on event_i[k] sets pending bit k on the next clock edge, whether or not bit k is masked. The bit then stays set until it is cleared.
- R4: Writing to address 0 clears every pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R5: If an event on bit k and a clear of bit k fall in the same cycle, bit k stays set.
- R6: The mask register takes the written value on implemented bits. A mask bit of 1 keeps its pending bit from driving irq_o, and a mask bit of 0 lets it through.
- R7: Bit 19 and bits 24:23 of both registers always read 0. An event on input bit 19 has no effect.
- R8: irq_o is high exactly when some pending bit has a clear mask bit, one clock edge after the register state changes, except during the gap cycle of R9.
- R9: A clear write at address 0 while irq_o is high drives irq_o low for one cycle. If unmasked bits are still pending, irq_o rises again on the following edge.
- R10: Writing all ones to the mask register masks every source and drops irq_o. Writing all ones to the pending register clears every pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| event_i | input | 23 | Single-cycle event pulses, one per source |
| acc_we | input | 1 | Register write strobe |
| acc_addr | input | 5 | Register address |
| acc_wdata | input | 25 | Register write word |
| acc_rdata | output | 25 | Read word for acc_addr (combinational) |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
Every one of the 25 bit positions is swept in turn through four steps: an event pulse while masked, unmasking that bit alone, a one-hot clear, and re-masking. Because the sweep covers every position, it separates the implemented bits from the hole at 19 and from the two unimplemented top bits. It also separates a mask that blocks its source from one that leaks. Further patterns check three things: two pending events with one of them cleared, which exposes the one-cycle low gap of R9; an event and a clear of the same bit in one cycle, which shows the set takes priority; and all-ones writes plus writes to unmapped addresses, which show the bulk clear and the address decode.

// File: rtl/irq_status_mask.sv
module irq_status_mask #(
  parameter int EVT_W     = 23,
  parameter int REG_W     = 25,
  parameter int ADDR_W    = 5,
  parameter int HOLE      = 19,
  parameter int STAT_ADDR = 0,
  parameter int MASK_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  event_i,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_W-1:0]  acc_wdata,
  output logic [REG_W-1:0]  acc_rdata,
  output logic              irq_o
);
  localparam logic [EVT_W-1:0] VLD = ~({{(EVT_W-1){1'b0}}, 1'b1} << HOLE);

  logic [EVT_W-1:0] stat_q, mask_q, stat_d, mask_d, ack_clr, wr_bits;
  logic stat_sel, mask_sel, pend_d, ack_gap;

  assign stat_sel = acc_addr == ADDR_W'(STAT_ADDR);
  assign mask_sel = acc_addr == ADDR_W'(MASK_ADDR);
  assign wr_bits  = acc_wdata[EVT_W-1:0];
  assign ack_clr  = (acc_we && stat_sel) ? wr_bits : '0;
  assign stat_d   = ((stat_q & ~ack_clr) | event_i) & VLD;
  assign mask_d   = (acc_we && mask_sel) ? (wr_bits & VLD) : mask_q;
  assign pend_d   = |(stat_d & ~mask_d);
  assign ack_gap  = irq_o && |(ack_clr & VLD);

  assign acc_rdata = stat_sel ? REG_W'(stat_q) :
                     mask_sel ? REG_W'(mask_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= VLD;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_o  <= pend_d && !ack_gap;
    end
  end
endmodule

// File: rtl/irq_status_mask_chk.sv
module irq_status_mask_chk #(
  parameter int EVT_W  = 23,
  parameter int REG_W  = 25,
  parameter int ADDR_W = 5,
  parameter int HOLE   = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EVT_W-1:0]  event_i,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [REG_W-1:0]  acc_wdata,
  input logic [REG_W-1:0]  acc_rdata,
  input logic              irq_o,
  input logic [EVT_W-1:0]  stat_q,
  input logic [EVT_W-1:0]  mask_q
);
  localparam logic [EVT_W-1:0] VLD = ~({{(EVT_W-1){1'b0}}, 1'b1} << HOLE);

  assert_irq_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(stat_q & ~mask_q));

  assert_event_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    |(event_i & VLD) |=> ((stat_q & $past(event_i & VLD)) == $past(event_i & VLD)));

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_addr == '0) |=> ((stat_q & $past(acc_wdata[EVT_W-1:0] & ~event_i)) == '0));

  assert_hole_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rdata[HOLE] && acc_rdata[REG_W-1:EVT_W] == '0);

  assert_reedge_after_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_o) && |(stat_q & ~mask_q) && !acc_we) |=> irq_o);
endmodule

bind irq_status_mask irq_status_mask_chk #(
  .EVT_W(EVT_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .HOLE(HOLE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .event_i(event_i), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
  .irq_o(irq_o), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/irq_status_mask_tb_top.sv
module irq_status_mask_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] event_i = '0;
  logic        acc_we = 1'b0;
  logic [4:0]  acc_addr = '0;
  logic [24:0] acc_wdata = '0;
  logic [24:0] acc_rdata;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [24:0] IMPL = 25'h07FFFFF & ~(25'h1 << 19);
  localparam logic [24:0] ONES = 25'h1FFFFFF;

  always #4 clk = ~clk;

  irq_status_mask dut_i (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [24:0] got, input logic [24:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%07h expected 0x%07h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input string req, input logic [24:0] exp);
    acc_addr = a;
    #1;
    chk(req, acc_rdata, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [24:0] d);
    @(negedge clk);
    acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_we = 1'b0; acc_wdata = '0;
  endtask

  task automatic ev(input logic [22:0] e);
    @(negedge clk);
    event_i = e;
    @(negedge clk);
    event_i = '0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, "R1 status", 25'h0);
    rd(1, "R1 mask", IMPL);
    chk("R1 irq", 25'(irq_o), 25'h0);

    for (int k = 0; k < 25; k++) begin
      logic [24:0] bitk;
      logic        valid;
      bitk  = 25'h1 << k;
      valid = (k < 23) && (k != 19);
      ev(k < 23 ? bitk[22:0] : 23'h0);
      rd(0, "R3 R7 latch while masked", valid ? bitk : 25'h0);
      chk("R6 masked irq", 25'(irq_o), 25'h0);
      wr(1, ~bitk);
      rd(1, "R6 mask readback", IMPL & ~bitk);
      chk("R8 irq after unmask", 25'(irq_o), 25'(valid));
      wr(0, bitk);
      rd(0, "R4 one-hot clear", 25'h0);
      @(negedge clk);
      chk("R8 irq after clear", 25'(irq_o), 25'h0);
      wr(1, ONES);
    end

    // R9: two pending, ack one -> one-cycle gap
    ev(23'h24);
    wr(1, 25'h0);
    chk("R8 irq two pending", 25'(irq_o), 25'h1);
    wr(0, 25'h4);
    chk("R9 gap low", 25'(irq_o), 25'h0);
    @(negedge clk);
    chk("R9 re-rise", 25'(irq_o), 25'h1);
    rd(0, "R9 remaining", 25'h20);

    // R4: zero write leaves state
    wr(0, 25'h0);
    rd(0, "R4 zero write", 25'h20);

    // R5: event wins over same-cycle clear
    ev(23'h10);
    @(negedge clk);
    acc_we = 1'b1; acc_addr = 0; acc_wdata = 25'h18; event_i = 23'h8;
    @(negedge clk);
    acc_we = 1'b0; acc_wdata = '0; event_i = '0;
    rd(0, "R5 event beats clear", 25'h28);

    // R2: unmapped addresses
    wr(2, ONES);
    wr(31, ONES);
    rd(2, "R2 unmapped read", 25'h0);
    rd(0, "R2 status untouched", 25'h28);
    rd(1, "R2 mask untouched", 25'h0);

    // R10: bulk mask and clear
    ev(23'h7FFFFF);
    wr(1, ONES);
    rd(1, "R10 mask all", IMPL);
    @(negedge clk);
    chk("R10 irq masked", 25'(irq_o), 25'h0);
    rd(0, "R7 status full", IMPL);
    wr(0, ONES);
    rd(0, "R10 clear all", 25'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule